// File: doc/BRIEF.md
# NMI Flag Register with Service Watchdog

This block gathers non-maskable interrupt sources into a flag register. Each enabled source that fires latches its own sticky flag. Any such event also sets a summary bit, which drives the NMI line to the CPU. Software clears flags by writing ones to them. The summary bit sits at position 0 of the readable flag vector. Source flag k sits at position k+1.

While the summary bit is set, a service watchdog counts system clock cycles. If the count reaches the programmed period before software clears the summary bit, the block raises a single-cycle device reset request. Clearing the summary bit while source flags are still pending does not silence the NMI. The summary bit drops for exactly one cycle, then sets again. This gives the CPU a fresh NMI edge and restarts the watchdog from zero. The counter holds its value while the CPU is in debug halt.

Top module: `nmi_wd_flags`

## Requirements
- R1: An event on source k with its enable high sets flag bit k+1 in the next cycle. A source whose enable is low leaves the flags unchanged.
- R2: Any enabled source event sets summary bit 0 in the next cycle. nmi_o always equals summary bit 0.
- R3: While the summary bit is clear, count_o is 0. While it is set, and halt_i is low, and count_o is below period_o, count_o rises by one each cycle, starting from 0.
- R4: When count_o is at or above period_o while the summary bit is set, dev_rst_o is high for exactly one cycle. The counter then stays at that value.
- R5: Writing clr_we_i with a 1 in mask bit j clears flag bit j. Mask bits of 0 change nothing. If a source event and a clear hit the same flag in one cycle, the flag stays set.
- R6: If the summary bit is cleared while any source flag is still set after that write, nmi_o is low for one cycle and then high again, with count_o restarting from 0.
- R7: While halt_i is high, count_o holds its value.
- R8: After reset, flags and count_o are 0, dev_rst_o is low, and period_o is all ones.
- R9: A write with prd_we_i loads prd_data_i into period_o in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | NMI source event lines |
| src_en_i | input | NUM_SRC | Per-source enables |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_mask_i | input | NUM_SRC+1 | Write-one-to-clear mask, bit 0 is the summary bit |
| halt_i | input | 1 | CPU debug halt, freezes the counter |
| prd_we_i | input | 1 | Period write strobe |
| prd_data_i | input | CNT_W | New period value |
| nmi_o | output | 1 | NMI to the CPU |
| dev_rst_o | output | 1 | Device reset request pulse |
| flags_o | output | NUM_SRC+1 | Flag register, summary at bit 0 |
| count_o | output | CNT_W | Watchdog counter value |
| period_o | output | CNT_W | Programmed period |

## Verification
Sources are driven both with their enables off and on. This shows that flag capture is gated per source rather than taken from the raw lines. The summary bit is cleared in two cases: once after every source flag has been cleared, and once with flags still pending. The first case must silence the NMI; the second must produce the one-cycle gap and a counter restart. A halt window in the middle of a count, a full run to expiry, a zero period and a clear that collides with a new event separate the freeze, single-pulse and priority rules from plain counting.

// File: rtl/nmi_wd_pkg.sv
package nmi_wd_pkg;
  typedef enum logic [1:0] {
    WD_IDLE,
    WD_RUN,
    WD_HOLD,
    WD_EXPIRED
  } wd_state_e;
endpackage

// File: rtl/nmi_flag_bank.sv
module nmi_flag_bank #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC:0]   clr_mask_i,
  output logic [NUM_SRC-1:0] src_flags_o,
  output logic               summary_o
);
  logic [NUM_SRC-1:0] hit;
  logic [NUM_SRC-1:0] clr_src;
  logic [NUM_SRC-1:0] flag_q;
  logic               sum_q, sum_d, sum_clr;

  assign hit     = src_i & src_en_i;
  assign clr_src = clr_we_i ? clr_mask_i[NUM_SRC:1] : '0;
  assign sum_clr = clr_we_i & clr_mask_i[0];

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
    // event wins over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[k] <= 1'b0;
      else         flag_q[k] <= hit[k] | (flag_q[k] & ~clr_src[k]);
    end
  end

  // a cleared summary re-arms from pending flags one cycle later
  always_comb begin
    if (|hit)       sum_d = 1'b1;
    else if (sum_q) sum_d = ~sum_clr;
    else            sum_d = |flag_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= 1'b0;
    else         sum_q <= sum_d;
  end

  assign src_flags_o = flag_q;
  assign summary_o   = sum_q;
endmodule

// File: rtl/nmi_wd_timer.sv
module nmi_wd_timer
  import nmi_wd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             summary_i,
  input  logic             halt_i,
  input  logic             prd_we_i,
  input  logic [CNT_W-1:0] prd_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] period_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] PrdReset = {CNT_W{1'b1}};

  wd_state_e        state;
  logic [CNT_W-1:0] cnt_q, cnt_d, prd_q;
  logic             done_q, fire, exp_q;

  always_comb begin
    if (!summary_i)         state = WD_IDLE;
    else if (cnt_q >= prd_q) state = WD_EXPIRED;
    else if (halt_i)        state = WD_HOLD;
    else                    state = WD_RUN;
  end

  always_comb begin
    unique case (state)
      WD_IDLE: cnt_d = '0;
      WD_RUN:  cnt_d = cnt_q + 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  assign fire = (state == WD_EXPIRED) && !done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prd_q  <= PrdReset;
      done_q <= 1'b0;
      exp_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      exp_q  <= fire;
      done_q <= summary_i & (done_q | fire);
      if (prd_we_i) prd_q <= prd_data_i;
    end
  end

  assign count_o  = cnt_q;
  assign period_o = prd_q;
  assign expire_o = exp_q;
endmodule

// File: rtl/nmi_wd_flags.sv
module nmi_wd_flags #(
  parameter int NUM_SRC = 8,
  parameter int CNT_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC:0]   clr_mask_i,
  input  logic               halt_i,
  input  logic               prd_we_i,
  input  logic [CNT_W-1:0]   prd_data_i,
  output logic               nmi_o,
  output logic               dev_rst_o,
  output logic [NUM_SRC:0]   flags_o,
  output logic [CNT_W-1:0]   count_o,
  output logic [CNT_W-1:0]   period_o
);
  logic [NUM_SRC-1:0] src_flags;
  logic               summary;

  nmi_flag_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (src_i),
    .src_en_i    (src_en_i),
    .clr_we_i    (clr_we_i),
    .clr_mask_i  (clr_mask_i),
    .src_flags_o (src_flags),
    .summary_o   (summary)
  );

  nmi_wd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .summary_i  (summary),
    .halt_i     (halt_i),
    .prd_we_i   (prd_we_i),
    .prd_data_i (prd_data_i),
    .count_o    (count_o),
    .period_o   (period_o),
    .expire_o   (dev_rst_o)
  );

  assign nmi_o   = summary;
  assign flags_o = {src_flags, summary};
endmodule

// File: rtl/nmi_wd_flags_chk.sv
module nmi_wd_flags_chk #(
  parameter int NUM_SRC = 8,
  parameter int CNT_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_i,
  input logic [NUM_SRC-1:0] src_en_i,
  input logic               clr_we_i,
  input logic [NUM_SRC:0]   clr_mask_i,
  input logic               halt_i,
  input logic               prd_we_i,
  input logic [CNT_W-1:0]   prd_data_i,
  input logic               nmi_o,
  input logic               dev_rst_o,
  input logic [NUM_SRC:0]   flags_o,
  input logic [CNT_W-1:0]   count_o,
  input logic [CNT_W-1:0]   period_o
);
  assert_src_sets_flag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i & src_en_i) != '0 |=>
      (flags_o[NUM_SRC:1] & $past(src_i & src_en_i)) == $past(src_i & src_en_i));

  assert_nmi_on_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i & src_en_i) != '0 |=> nmi_o && flags_o[0]);

  assert_idle_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nmi_o |=> count_o == '0);

  assert_rst_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_o |=> !dev_rst_o);

  assert_retrigger_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o && clr_we_i && clr_mask_i[0] && ((src_i & src_en_i) == '0) &&
    ((flags_o[NUM_SRC:1] & ~clr_mask_i[NUM_SRC:1]) != '0) |=> !nmi_o ##1 nmi_o);

  assert_halt_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o && halt_i |=> $stable(count_o));

  assert_period_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prd_we_i |=> period_o == $past(prd_data_i));
endmodule

bind nmi_wd_flags nmi_wd_flags_chk #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/nmi_wd_flags_bench.sv
module nmi_wd_flags_bench;
  localparam int NS = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0, en = '0;
  logic          clr_we = 1'b0, halt = 1'b0, prd_we = 1'b0;
  logic [NS:0]   mask = '0;
  logic [CW-1:0] prd_data = '0;
  logic          nmi, dev_rst;
  logic [NS:0]   flags;
  logic [CW-1:0] count, period;

  // reference state
  logic          m_sum = 1'b0, m_done = 1'b0, m_rst = 1'b0;
  logic [NS-1:0] m_flags = '0;
  logic [CW-1:0] m_cnt = '0, m_prd = '1;

  int checks = 0, errors = 0, cyc = 0;
  bit done_run = 1'b0;

  always #2.5 clk = ~clk;

  nmi_wd_flags #(.NUM_SRC(NS), .CNT_W(CW)) u_nmi_wd_flags (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .src_en_i(en),
    .clr_we_i(clr_we), .clr_mask_i(mask), .halt_i(halt),
    .prd_we_i(prd_we), .prd_data_i(prd_data), .nmi_o(nmi),
    .dev_rst_o(dev_rst), .flags_o(flags), .count_o(count), .period_o(period));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [NS-1:0] hit;
    logic          n_sum, fire;
    hit   = src & en;
    n_sum = (hit != '0) ? 1'b1 : (m_sum ? !(clr_we && mask[0]) : (m_flags != '0));
    fire  = m_sum && (m_cnt >= m_prd) && !m_done;
    m_done = m_sum && (m_done || fire);
    m_rst  = fire;
    if (!m_sum)               m_cnt = '0;
    else if (m_cnt < m_prd && !halt) m_cnt = m_cnt + 1'b1;
    m_flags = hit | (m_flags & ~(clr_we ? mask[NS:1] : '0));
    m_sum   = n_sum;
    if (prd_we) m_prd = prd_data;
  endtask

  task automatic compare();
    chk(flags[NS:1] == m_flags, "R1/R5 flags", flags[NS:1], m_flags);
    chk(nmi == m_sum && flags[0] == m_sum, "R2 summary", nmi, m_sum);
    chk(count == m_cnt, "R3 count", count, m_cnt);
    chk(dev_rst == m_rst, "R4 dev_rst", dev_rst, m_rst);
    chk(period == m_prd, "R9 period", period, m_prd);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    src = '0; clr_we = 1'b0; mask = '0; prd_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    while (!done_run) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog expired expected=run end");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset values
    chk(flags == '0 && count == '0 && !dev_rst && !nmi, "R8 reset state", {flags, count}, 0);
    chk(period == '1, "R8 reset period", period, 16'hFFFF);
    rst_n = 1'b1;
    tick();
    prd_we = 1'b1; prd_data = 16'd10; tick();         // R9
    src = 8'h04; en = 8'h00; tick();                  // R1: disabled source
    chk(flags == '0 && !nmi, "R1 disabled source ignored", flags, 0);
    en = 8'hFF;
    src = 8'h08; tick();                              // R1/R2 source 3 -> bit 4
    chk(flags == 9'h011 && nmi, "R1 flag bit4 set", flags, 9'h011);
    ticks(4);
    chk(count == 16'd4, "R3 count after 4", count, 4);
    halt = 1'b1; ticks(5);                            // R7
    chk(count == 16'd4, "R7 held in halt", count, 4);
    halt = 1'b0; ticks(6);
    chk(count == 16'd10, "R4 reached period", count, 10);
    tick();
    chk(dev_rst, "R4 pulse high", dev_rst, 1);
    tick();
    chk(!dev_rst && count == 16'd10, "R4 single pulse", dev_rst, 0);
    ticks(3);
    clr_we = 1'b1; mask = 9'h010; tick();             // R5 W1C
    chk(flags == 9'h001, "R5 flag cleared", flags, 9'h001);
    clr_we = 1'b1; mask = 9'h001; tick();
    chk(!nmi && flags == '0, "R5 summary cleared", flags, 0);
    ticks(2);
    chk(count == '0, "R3 idle count zero", count, 0);
    src = 8'h03; tick(); ticks(3);                    // R6 retrigger
    clr_we = 1'b1; mask = 9'h005; tick();             // clears summary and source 1 only
    chk(!nmi && flags == 9'h002, "R6 summary dropped", flags, 9'h002);
    tick();
    chk(nmi && count == '0, "R6 summary re-set", nmi, 1);
    ticks(2);
    chk(count == 16'd2, "R6 counter restarted", count, 2);
    src = 8'h01; clr_we = 1'b1; mask = 9'h003; tick(); // R5 event beats clear
    chk(flags == 9'h003, "R5 event wins over clear", flags, 9'h003);
    clr_we = 1'b1; mask = 9'h1FE; tick();
    clr_we = 1'b1; mask = 9'h001; tick(); ticks(2);
    chk(!nmi, "R5 all cleared", nmi, 0);
    prd_we = 1'b1; prd_data = '0; tick();             // zero period corner
    src = 8'h80; tick();
    tick();
    chk(dev_rst, "R4 zero period fires", dev_rst, 1);
    ticks(3);
    done_run = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule